// File: doc/BRIEF.md
# Single-Character Serial Port with Register Interface

This block is a small register-mapped asynchronous serial port. Software reaches it through a plain valid/write/address/data slave port. It holds one character in each direction. A transmit holding register feeds a shift register that drives the serial output. A receive shift register fills a one-character receive holding register. Every frame is fixed at one start bit, eight data bits sent least significant bit first, no parity and one stop bit.

The bit time is a whole number of system clocks, taken from a 21-bit divisor register. There is no oversampling. The receiver waits for a falling edge on its double-synchronised input and then samples each bit near its centre.

Three interrupt outputs report receive, transmit and overrun events. Each output is the AND of a sticky flag and its enable. Software clears a flag by writing one to it. Both overrun events share the third output.

Top module: `byte_serial_port`

## Requirements
- R1: Register offsets are DATA 0x00, STATE 0x04, CTRL 0x08, INT 0x0C and DIV 0x10. Unmapped offsets read as zero. After reset CTRL, STATE and INT read 0, DIV reads 16, the serial output is high and all interrupt outputs are low.
- R2: STATE bit 0 means the transmit holding register is full, bit 1 means the receive holding register is full, bit 2 is transmit overrun and bit 3 is receive overrun. Writing 1 to STATE bit 2 or bit 3 clears that overrun bit.
- R3: CTRL bit 0 enables the transmitter and bit 1 enables the receiver. Bits 2, 3, 4 and 5 enable the transmit, receive, transmit-overrun and receive-overrun interrupts. CTRL reads back what was written.
- R4: Writing DATA loads the transmit holding register and sets STATE bit 0. While CTRL bit 0 is set, the shifter takes the byte and clears STATE bit 0. It then sends start (low), eight data bits LSB first and stop (high), each bit lasting DIV clock cycles.
- R5: INT bit 0 is set when the shifter takes a byte, but only if CTRL bit 2 is set at that moment. irq_tx is INT bit 0 AND CTRL bit 2. Writing 1 to INT bit 0 clears it.
- R6: A DATA write while STATE bit 0 is set drops the new byte, sets STATE bit 2 and sets INT bit 2. The byte already held is the one sent.
- R7: While CTRL bit 1 is set, a received frame with a high stop bit lands in the receive holding register. It sets STATE bit 1 and INT bit 1. irq_rx is INT bit 1 AND CTRL bit 3. Reading DATA returns the byte in bits 7:0 and clears STATE bit 1.
- R8: A frame that completes while STATE bit 1 is set is discarded. The old byte is kept, and STATE bit 3 and INT bit 3 are set.
- R9: A frame whose stop bit samples low is discarded and leaves STATE and INT unchanged.
- R10: irq_ovr is high when INT bit 2 and CTRL bit 4 are both set, or when INT bit 3 and CTRL bit 5 are both set. Writing 1 to INT bit 2 or bit 3 clears that flag.
- R11: DIV holds 21 bits. A written value below 16 is stored as 16. Any other value sets the bit time of both directions.
- R12: Clearing CTRL bit 0 aborts a frame in progress and holds the serial output high from the next cycle on. While CTRL bit 1 is clear, incoming frames are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read access |
| ser_txd | output | 1 | Serial output, idle high |
| ser_rxd | input | 1 | Serial input, asynchronous |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_ovr | output | 1 | Combined overrun interrupt |

## Verification
The bench writes a second byte while the transmit register is still full, with the transmitter disabled. A design that overwrote instead of dropping would send the wrong byte, or it would fail to raise the overrun bit. It sends two frames without reading in between. A design that let the newer byte win would return the wrong character.

It also sends a frame with a low stop bit, which a receiver that ignored the stop bit would accept. It checks that the transmit flag stays clear when the shifter takes a byte with the transmit interrupt disabled. It checks that a divisor written below the minimum is stored as the minimum. It disables the transmitter mid-frame, which a design that finishes the frame first would get wrong.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

    localparam int ADDR_W    = 5;
    localparam int BUS_W     = 32;
    localparam int CHAR_W    = 8;
    localparam int DIV_W     = 21;
    localparam int DIV_MIN   = 16;
    localparam int FRAME_LEN = CHAR_W + 2;
    localparam int BITCNT_W  = $clog2(FRAME_LEN + 1);

    localparam logic [ADDR_W-1:0] OFS_DATA  = ADDR_W'(5'h00);
    localparam logic [ADDR_W-1:0] OFS_STATE = ADDR_W'(5'h04);
    localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'(5'h08);
    localparam logic [ADDR_W-1:0] OFS_INT   = ADDR_W'(5'h0C);
    localparam logic [ADDR_W-1:0] OFS_DIV   = ADDR_W'(5'h10);

    // Control fields; bit 0 is the last member.
    typedef struct packed {
        logic rxo_ie;
        logic txo_ie;
        logic rx_ie;
        logic tx_ie;
        logic rx_en;
        logic tx_en;
    } ctrl_t;

    // Event flags shared by the INT layout; bit 0 is the last member.
    typedef struct packed {
        logic rx_ovr;
        logic tx_ovr;
        logic rx;
        logic tx;
    } evt_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_BITS,
        RX_STOP
    } rx_phase_e;

    function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] v);
        return (v < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) : v;
    endfunction

endpackage

// File: rtl/bsp_tx.sv
module bsp_tx
    import bsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [DIV_W-1:0]  div,
    input  logic              hold_full,
    input  logic [CHAR_W-1:0] hold_data,
    output logic              take,
    output logic              line_o
);
    logic                 busy_q;
    logic [FRAME_LEN-1:0] shreg_q;
    logic [DIV_W-1:0]     cnt_q;
    logic [BITCNT_W-1:0]  bitn_q;

    assign take   = en && !busy_q && hold_full;
    assign line_o = busy_q ? shreg_q[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            busy_q  <= 1'b0;
            shreg_q <= '1;
            cnt_q   <= '0;
            bitn_q  <= '0;
        end else if (take) begin
            busy_q  <= 1'b1;
            shreg_q <= {1'b1, hold_data, 1'b0};
            cnt_q   <= div - 1'b1;
            bitn_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                if (bitn_q == BITCNT_W'(FRAME_LEN - 1)) begin
                    busy_q <= 1'b0;
                end else begin
                    shreg_q <= {1'b1, shreg_q[FRAME_LEN-1:1]};
                    bitn_q  <= bitn_q + 1'b1;
                    cnt_q   <= div - 1'b1;
                end
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R12: a disabled transmitter idles high on the following cycle
    a_r12_tx_idle_when_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> line_o);

    // R4: a new frame always begins with a low start bit
    a_r4_start_low: assert property (@(posedge clk) disable iff (rst)
        take |=> !line_o);

endmodule

// File: rtl/bsp_rx.sv
module bsp_rx
    import bsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [DIV_W-1:0]  div,
    input  logic              line_i,
    output logic              done,
    output logic [CHAR_W-1:0] data
);
    logic                meta_q, sync_q, prev_q;
    rx_phase_e           phase_q;
    logic [DIV_W-1:0]    cnt_q;
    logic [BITCNT_W-1:0] bitn_q;
    logic [CHAR_W-1:0]   shreg_q;
    logic                done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= line_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    always_ff @(posedge clk) begin
        done_q <= 1'b0;
        if (rst || !en) begin
            phase_q <= RX_IDLE;
            cnt_q   <= '0;
            bitn_q  <= '0;
            shreg_q <= '0;
            done_q  <= 1'b0;
        end else begin
            case (phase_q)
                RX_IDLE: if (prev_q && !sync_q) begin
                    phase_q <= RX_START;
                    cnt_q   <= (div >> 1) - 1'b1;
                end
                RX_START: if (cnt_q == '0) begin
                    if (!sync_q) begin
                        phase_q <= RX_BITS;
                        cnt_q   <= div - 1'b1;
                        bitn_q  <= '0;
                    end else begin
                        phase_q <= RX_IDLE;
                    end
                end else cnt_q <= cnt_q - 1'b1;
                RX_BITS: if (cnt_q == '0) begin
                    shreg_q <= {sync_q, shreg_q[CHAR_W-1:1]};
                    cnt_q   <= div - 1'b1;
                    if (bitn_q == BITCNT_W'(CHAR_W - 1)) phase_q <= RX_STOP;
                    else bitn_q <= bitn_q + 1'b1;
                end else cnt_q <= cnt_q - 1'b1;
                RX_STOP: if (cnt_q == '0) begin
                    done_q  <= sync_q;
                    phase_q <= RX_IDLE;
                end else cnt_q <= cnt_q - 1'b1;
                default: phase_q <= RX_IDLE;
            endcase
        end
    end

    assign done = done_q;
    assign data = shreg_q;

    // R9: a completed character follows a stop sample taken in the stop phase
    a_r9_done_from_stop: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(phase_q) == RX_STOP));

    // R12: nothing is received while disabled
    a_r12_rx_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> !done);

endmodule

// File: rtl/byte_serial_port.sv
module byte_serial_port
    import bsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              ser_txd,
    input  logic              ser_rxd,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              irq_ovr
);
    localparam int CTRL_W = $bits(ctrl_t);
    localparam int EVT_W  = $bits(evt_t);

    ctrl_t             ctrl_q;
    evt_t              int_q;
    logic              tx_full_q, rx_full_q;
    logic              tx_ovr_q, rx_ovr_q;
    logic [CHAR_W-1:0] tx_hold_q, rx_hold_q;
    logic [DIV_W-1:0]  div_q;

    logic              wr, rd, wr_data, pop, wr_state, wr_int;
    logic              take, rx_done, rx_land, rx_clash, tx_accept, tx_drop;
    logic [CHAR_W-1:0] rx_byte;

    assign wr       = bus_valid && bus_write;
    assign rd       = bus_valid && !bus_write;
    assign wr_data  = wr && (bus_addr == OFS_DATA);
    assign wr_state = wr && (bus_addr == OFS_STATE);
    assign wr_int   = wr && (bus_addr == OFS_INT);
    assign pop      = rd && (bus_addr == OFS_DATA);

    assign tx_accept = wr_data && (!tx_full_q || take);
    assign tx_drop   = wr_data && tx_full_q && !take;
    assign rx_clash  = rx_done && rx_full_q && !pop;
    assign rx_land   = rx_done && !rx_clash;

    bsp_tx u_tx (
        .clk       (clk),
        .rst       (rst),
        .en        (ctrl_q.tx_en),
        .div       (div_q),
        .hold_full (tx_full_q),
        .hold_data (tx_hold_q),
        .take      (take),
        .line_o    (ser_txd)
    );

    bsp_rx u_rx (
        .clk    (clk),
        .rst    (rst),
        .en     (ctrl_q.rx_en),
        .div    (div_q),
        .line_i (ser_rxd),
        .done   (rx_done),
        .data   (rx_byte)
    );

    // Configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            div_q  <= DIV_W'(DIV_MIN);
        end else if (wr) begin
            if (bus_addr == OFS_CTRL) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (bus_addr == OFS_DIV)  div_q  <= clamp_div(bus_wdata[DIV_W-1:0]);
        end
    end

    // Transmit holding register
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_full_q <= 1'b0;
            tx_hold_q <= '0;
            tx_ovr_q  <= 1'b0;
        end else begin
            if (take) tx_full_q <= 1'b0;
            if (tx_accept) begin
                tx_full_q <= 1'b1;
                tx_hold_q <= bus_wdata[CHAR_W-1:0];
            end
            if (wr_state && bus_wdata[2]) tx_ovr_q <= 1'b0;
            if (tx_drop) tx_ovr_q <= 1'b1;
        end
    end

    // Receive holding register
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_full_q <= 1'b0;
            rx_hold_q <= '0;
            rx_ovr_q  <= 1'b0;
        end else begin
            if (pop) rx_full_q <= 1'b0;
            if (rx_land) begin
                rx_full_q <= 1'b1;
                rx_hold_q <= rx_byte;
            end
            if (wr_state && bus_wdata[3]) rx_ovr_q <= 1'b0;
            if (rx_clash) rx_ovr_q <= 1'b1;
        end
    end

    // Interrupt flags: write-one-to-clear, a new event in the same cycle wins
    evt_t set_evt;
    always_comb begin
        set_evt        = '0;
        set_evt.tx     = take && ctrl_q.tx_ie;
        set_evt.rx     = rx_land;
        set_evt.tx_ovr = tx_drop;
        set_evt.rx_ovr = rx_clash;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            int_q <= '0;
        end else begin
            for (int i = 0; i < EVT_W; i++) begin
                if (set_evt[i])                     int_q[i] <= 1'b1;
                else if (wr_int && bus_wdata[i])    int_q[i] <= 1'b0;
            end
        end
    end

    assign irq_tx  = int_q.tx && ctrl_q.tx_ie;
    assign irq_rx  = int_q.rx && ctrl_q.rx_ie;
    assign irq_ovr = (int_q.tx_ovr && ctrl_q.txo_ie) || (int_q.rx_ovr && ctrl_q.rxo_ie);

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            case (bus_addr)
                OFS_DATA:  bus_rdata[CHAR_W-1:0] = rx_hold_q;
                OFS_STATE: bus_rdata[3:0]        = {rx_ovr_q, tx_ovr_q, rx_full_q, tx_full_q};
                OFS_CTRL:  bus_rdata[CTRL_W-1:0] = ctrl_q;
                OFS_INT:   bus_rdata[EVT_W-1:0]  = int_q;
                OFS_DIV:   bus_rdata[DIV_W-1:0]  = div_q;
                default:   bus_rdata = '0;
            endcase
        end
    end

    // R6: a write into a full transmit register leaves the held byte alone and flags overrun
    a_r6_drop_keeps_hold: assert property (@(posedge clk) disable iff (rst)
        tx_drop |=> ($stable(tx_hold_q) && tx_ovr_q && int_q.tx_ovr));

    // R8: a clashing character does not replace the held one
    a_r8_keep_old_byte: assert property (@(posedge clk) disable iff (rst)
        rx_clash |=> ($stable(rx_hold_q) && rx_full_q && rx_ovr_q));

    // R4: the shifter only takes a byte out of a full holding register
    a_r4_take_needs_full: assert property (@(posedge clk) disable iff (rst)
        take |-> tx_full_q);

    // R11: divisor never below the floor
    a_r11_div_floor: assert property (@(posedge clk) disable iff (rst)
        wr && (bus_addr == OFS_DIV) |=> (div_q >= DIV_W'(DIV_MIN)));

    // R7: receive flag clears on write-one unless a new byte lands together
    a_r7_rx_w1c: assert property (@(posedge clk) disable iff (rst)
        (wr_int && bus_wdata[1] && !rx_land) |=> !int_q.rx);

endmodule

// File: tb/byte_serial_port_test.sv
module byte_serial_port_test;
    import bsp_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [BUS_W-1:0]  bus_wdata = '0;
    logic [BUS_W-1:0]  bus_rdata;
    logic              ser_txd;
    logic              ser_rxd = 1'b1;
    logic              irq_tx, irq_rx, irq_ovr;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    byte_serial_port uut (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ser_txd(ser_txd), .ser_rxd(ser_rxd),
        .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_ovr(irq_ovr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic cap_tx(input int div, output logic [7:0] b, output logic stop);
        int guard = 0;
        @(negedge clk);
        while (ser_txd === 1'b1 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        repeat (div / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (div) @(negedge clk);
            b[i] = ser_txd;
        end
        repeat (div) @(negedge clk);
        stop = ser_txd;
    endtask

    task automatic send_rx(input int div, input logic [7:0] b, input logic stop_bit);
        @(negedge clk);
        ser_rxd = 1'b0;
        repeat (div) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            ser_rxd = b[i];
            repeat (div) @(negedge clk);
        end
        ser_rxd = stop_bit;
        repeat (div) @(negedge clk);
        ser_rxd = 1'b1;
        repeat (div) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        bus_rd(OFS_CTRL, d);  chk("R1 ctrl reset", d, 0);
        bus_rd(OFS_STATE, d); chk("R1 state reset", d, 0);
        bus_rd(OFS_INT, d);   chk("R1 int reset", d, 0);
        bus_rd(OFS_DIV, d);   chk("R1 div reset", d, 16);
        bus_rd(5'h14, d);     chk("R1 unmapped reads zero", d, 0);
        chk("R1 txd idle", {31'b0, ser_txd}, 1);
        chk("R1 irqs low", {29'b0, irq_tx, irq_rx, irq_ovr}, 0);
    endtask

    task automatic t_tx_overrun;
        logic [31:0] d; logic [7:0] b; logic s;
        bus_wr(OFS_DATA, 32'hA5);
        bus_rd(OFS_STATE, d); chk("R4 tx full set", d, 32'h1);
        bus_wr(OFS_DATA, 32'h3C);
        bus_rd(OFS_STATE, d); chk("R6 tx overrun state", d, 32'h5);
        bus_rd(OFS_INT, d);   chk("R6 tx overrun int", d, 32'h4);
        chk("R10 ovr masked", {31'b0, irq_ovr}, 0);
        bus_wr(OFS_CTRL, 32'h15);
        bus_rd(OFS_CTRL, d);  chk("R3 ctrl readback", d, 32'h15);
        chk("R10 ovr irq", {31'b0, irq_ovr}, 1);
        cap_tx(16, b, s);
        chk("R6 held byte sent", {24'b0, b}, 32'hA5);
        chk("R4 stop high", {31'b0, s}, 1);
        bus_rd(OFS_STATE, d); chk("R4 tx full cleared", d, 32'h4);
        chk("R5 irq_tx raised", {31'b0, irq_tx}, 1);
        bus_wr(OFS_INT, 32'h1);
        chk("R5 irq_tx cleared", {31'b0, irq_tx}, 0);
        bus_wr(OFS_INT, 32'h4);
        chk("R10 ovr cleared", {31'b0, irq_ovr}, 0);
        bus_wr(OFS_STATE, 32'h4);
        bus_rd(OFS_STATE, d); chk("R2 overrun w1c", d, 0);
    endtask

    task automatic t_tx_noirq_div;
        logic [31:0] d; logic [7:0] b; logic s;
        bus_wr(OFS_DIV, 32'd5);
        bus_rd(OFS_DIV, d); chk("R11 clamp", d, 16);
        bus_wr(OFS_DIV, 32'd40);
        bus_rd(OFS_DIV, d); chk("R11 div store", d, 40);
        bus_wr(OFS_CTRL, 32'h01);
        bus_wr(OFS_DATA, 32'h6E);
        cap_tx(40, b, s);
        chk("R11 byte at div 40", {24'b0, b}, 32'h6E);
        chk("R11 stop at div 40", {31'b0, s}, 1);
        bus_rd(OFS_INT, d); chk("R5 no flag when disabled", d, 0);
        bus_wr(OFS_DIV, 32'd16);
    endtask

    task automatic t_tx_abort;
        bus_wr(OFS_CTRL, 32'h01);
        bus_wr(OFS_DATA, 32'h00);
        repeat (30) @(negedge clk);
        chk("R12 mid-frame low", {31'b0, ser_txd}, 0);
        bus_wr(OFS_CTRL, 32'h00);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (ser_txd !== 1'b1) begin
                chk("R12 line idle after disable", {31'b0, ser_txd}, 1);
                break;
            end
        end
        chk("R12 txd high", {31'b0, ser_txd}, 1);
    endtask

    task automatic t_rx;
        logic [31:0] d;
        bus_wr(OFS_CTRL, 32'h0A);
        send_rx(16, 8'h3C, 1'b1);
        bus_rd(OFS_STATE, d); chk("R7 rx full", d, 32'h2);
        chk("R7 irq_rx", {31'b0, irq_rx}, 1);
        bus_rd(OFS_DATA, d);  chk("R7 rx data", d, 32'h3C);
        bus_rd(OFS_STATE, d); chk("R7 popped", d, 0);
        bus_wr(OFS_INT, 32'h2);
        chk("R7 irq_rx cleared", {31'b0, irq_rx}, 0);
    endtask

    task automatic t_rx_overrun;
        logic [31:0] d;
        bus_wr(OFS_CTRL, 32'h22);
        send_rx(16, 8'h81, 1'b1);
        send_rx(16, 8'h7E, 1'b1);
        bus_rd(OFS_STATE, d); chk("R8 overrun state", d, 32'hA);
        chk("R10 rx ovr irq", {31'b0, irq_ovr}, 1);
        bus_rd(OFS_DATA, d);  chk("R8 old byte kept", d, 32'h81);
        bus_wr(OFS_STATE, 32'h8);
        bus_wr(OFS_INT, 32'hF);
        bus_rd(OFS_STATE, d); chk("R2 rx overrun w1c", d, 0);
        chk("R10 ovr low", {31'b0, irq_ovr}, 0);
    endtask

    task automatic t_rx_badstop_off;
        logic [31:0] d;
        send_rx(16, 8'h55, 1'b0);
        repeat (20) @(negedge clk);
        bus_rd(OFS_STATE, d); chk("R9 bad stop dropped", d, 0);
        bus_rd(OFS_INT, d);   chk("R9 no flag", d, 0);
        bus_wr(OFS_CTRL, 32'h00);
        send_rx(16, 8'hC3, 1'b1);
        bus_rd(OFS_STATE, d); chk("R12 rx off ignored", d, 0);
        bus_rd(OFS_INT, d);   chk("R12 rx off no flag", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_tx_overrun();
        t_tx_noirq_div();
        t_tx_abort();
        t_rx();
        t_rx_overrun();
        t_rx_badstop_off();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule